// File: doc/BRIEF.md
# Two-Stage Load-Balanced Cell Switch

This block is a cell switch fabric with `N` external ports that does no arbitration. Each port presents at most one fixed-size cell per time slot, tagged with the external output it is bound for. There are two crossbar stages, and the queues sit between them. The first stage spreads arriving cells over the middle ports. It follows a cyclic permutation that advances every slot and does not look at the traffic. Each middle port holds one FIFO per external output. The second stage then connects each middle port to one external output, again by a cyclic permutation that advances every slot. Through that connection the middle port sends the oldest cell waiting for that output.

Over one cycle of `N` slots each stage connects every input-output pair exactly once. The load is therefore balanced without any request or grant logic. A cell that arrives at a full queue is discarded, and the discard is counted for that middle port. Cells of one flow can leave out of order, because they cross different middle ports. Reordering is left to the logic downstream.

Top module: `lbsw_fabric`

## Requirements
- R1: While `rst_n` is low at a clock edge, the slot counter returns to 0, every queue empties and every drop counter clears. After reset no `out_valid` bit is set.
- R2: The first slot after reset is slot 0. The slot number advances by one each clock and goes from N-1 back to 0.
- R3: In slot t, a valid cell on external input i is offered to middle port (i + t) mod N, into the queue named by its destination tag. It is stored at the clock edge that ends slot t, with no buffering in the first stage.
- R4: In slot t, middle port m is connected to external output (m + t) mod N. It presents the head of its queue for that output when that queue is non-empty. Otherwise that output shows `out_valid` = 0 for the slot, and the head leaves the queue at the end of the slot.
- R5: Cells that share a middle port and a destination leave in the order in which they arrived.
- R6: A queue is full when it holds DEPTH cells at the start of the slot. A cell offered to a full queue is discarded, and the `drop_count` field of that middle port goes up by one. Every other queue is left unchanged.
- R7: A cell leaving on output o carries destination tag o and the payload it entered with. The tag of port k is bits [k*TW +: TW], with TW = clog2(N). The payload of port k is bits [k*PAYLOAD_W +: PAYLOAD_W].
- R8: Each cell that is not discarded leaves exactly once, on the output named by its tag.
- R9: A cell cannot leave in the slot in which it arrives.
- R10: A full queue can pop in the same slot in which a cell is offered to it. The offered cell is still discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cell time slot per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | N | Cell present on each external input |
| in_dest | input | N*TW | Destination tag per external input |
| in_data | input | N*PAYLOAD_W | Payload per external input |
| out_valid | output | N | Cell present on each external output |
| out_dest | output | N*TW | Destination tag of the departing cell |
| out_data | output | N*PAYLOAD_W | Payload of the departing cell |
| drop_count | output | N*CNT_W | Discarded-cell count per middle port |

## Verification
The case that is hardest to reach from the ports is a full queue that pops in the same slot in which a new cell is offered to it. A queue only fills when arrivals for one output stay ahead of the one-slot-in-N service that output receives. The stimulus therefore runs a hotspot phase in which every input sends to the same output in every slot. This drives each middle port's queue for that output to DEPTH and keeps it there, so pops and discarded offers coincide. Uniform random traffic, single isolated cells and a final drain check the cyclic mappings, the per-queue order and the exactly-once delivery against a behavioural model of the queues.

// File: rtl/lbsw_pkg.sv
// Package: shared helpers for the load-balanced switch.
// Assumes operands already lie in [0, n).
package lbsw_pkg;

    // (a + b) mod n for port and slot indices
    function automatic int wrap_add(input int a, input int b, input int n);
        return (a + b) % n;
    endfunction

    // (a - b) mod n for port and slot indices
    function automatic int wrap_sub(input int a, input int b, input int n);
        return (a - b + n) % n;
    endfunction

endpackage

// File: rtl/lbsw_slot_ctr.sv
// Module: slot sequencer shared by both crossbar stages.
// Counts time slots 0..N-1 and wraps; a single counter drives both
// permutations, so their phases can never drift apart.
module lbsw_slot_ctr #(
    parameter int N  = 4,
    localparam int TW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [TW-1:0] slot
);

    // advance the slot number once per clock, wrapping at N
    always_ff @(posedge clk) begin
        if (!rst_n)                 slot <= '0;
        else if (slot == TW'(N-1))  slot <= '0;
        else                        slot <= slot + TW'(1);
    end

    p_slot_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == TW'(N-1)) |=> (slot == '0));
    p_slot_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (slot != TW'(N-1)) |=> (slot == $past(slot) + TW'(1)));

endmodule

// File: rtl/lbsw_voq_fifo.sv
// Module: one virtual output queue, a circular FIFO of DEPTH entries.
// Full and empty are judged on the state at the start of the slot, so
// a write offered while full is refused even if a read happens too.
module lbsw_voq_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_cell,
    input  logic         rd_en,
    output logic         head_vld,
    output logic [W-1:0] head_cell,
    output logic         wr_refused
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rptr, wptr;
    logic [CW-1:0] cnt;
    logic          full, wr_ok, rd_ok;

    // decode full, empty and accepted operations from the current state
    always_comb begin
        full       = (cnt == CW'(DEPTH));
        head_vld   = (cnt != '0);
        head_cell  = mem[rptr];
        wr_ok      = wr_en && !full;
        rd_ok      = rd_en && head_vld;
        wr_refused = wr_en && full;
    end

    // update the pointers and the occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr <= '0;
            wptr <= '0;
            cnt  <= '0;
        end else begin
            if (wr_ok) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + AW'(1);
            if (rd_ok) rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + AW'(1);
            cnt <= cnt + CW'(wr_ok) - CW'(rd_ok);
        end
    end

    // storage write, no reset needed
    always_ff @(posedge clk) begin
        if (wr_ok) mem[wptr] <= wr_cell;
    end

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full) |=> (cnt <= $past(cnt)));
    p_pop_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && head_vld && !wr_en) |=> (cnt == $past(cnt) - CW'(1)));
    p_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));

endmodule

// File: rtl/lbsw_mid_port.sv
// Module: one middle port holding N virtual output queues.
// Takes at most one cell per slot from the first stage and sends at
// most one cell per slot to the output the second stage connects it to.
module lbsw_mid_port #(
    parameter int N         = 4,
    parameter int MID       = 0,
    parameter int DEPTH     = 8,
    parameter int PAYLOAD_W = 16,
    parameter int CNT_W     = 16,
    localparam int TW = (N > 1) ? $clog2(N) : 1,
    localparam int CELL_W = TW + PAYLOAD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TW-1:0]     slot,
    input  logic              arr_vld,
    input  logic [CELL_W-1:0] arr_cell,
    output logic [TW-1:0]     conn_out,
    output logic              dep_vld,
    output logic [CELL_W-1:0] dep_cell,
    output logic [CNT_W-1:0]  drops
);
    import lbsw_pkg::*;

    logic [N-1:0]      q_wr, q_rd, q_vld, q_ref;
    logic [CELL_W-1:0] q_head [N];
    logic [TW-1:0]     arr_dest;
    logic              refused;

    // second-stage connection for this port in the current slot
    always_comb begin
        conn_out = TW'(wrap_add(MID, int'(slot), N));
        arr_dest = arr_cell[CELL_W-1 -: TW];
    end

    // steer the arrival to its queue and the read to the connected queue
    always_comb begin
        for (int k = 0; k < N; k++) begin
            q_wr[k] = arr_vld && (arr_dest == TW'(k));
            q_rd[k] = (conn_out == TW'(k));
        end
        dep_vld  = q_vld[conn_out];
        dep_cell = q_head[conn_out];
        refused  = |q_ref;
    end

    for (genvar k = 0; k < N; k++) begin : g_voq
        lbsw_voq_fifo #(.DEPTH(DEPTH), .W(CELL_W)) voq_i (
            .clk(clk), .rst_n(rst_n),
            .wr_en(q_wr[k]), .wr_cell(arr_cell),
            .rd_en(q_rd[k]),
            .head_vld(q_vld[k]), .head_cell(q_head[k]),
            .wr_refused(q_ref[k])
        );
    end

    // count cells refused by a full queue
    always_ff @(posedge clk) begin
        if (!rst_n)       drops <= '0;
        else if (refused) drops <= drops + CNT_W'(1);
    end

    p_drop_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        refused |=> (drops == $past(drops) + CNT_W'(1)));
    p_single_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(q_wr));

endmodule

// File: rtl/lbsw_fabric.sv
// Module: top of the two-stage load-balanced cell switch.
// Stage one maps input i to middle (i+t) mod N and stage two maps
// middle m to output (m+t) mod N. Neither stage looks at the traffic.
// Assumes one cell per input per slot; reordering is left downstream.
module lbsw_fabric #(
    parameter int N         = 4,
    parameter int DEPTH     = 8,
    parameter int PAYLOAD_W = 16,
    parameter int CNT_W     = 16,
    localparam int TW = (N > 1) ? $clog2(N) : 1,
    localparam int CELL_W = TW + PAYLOAD_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N-1:0]           in_valid,
    input  logic [N*TW-1:0]        in_dest,
    input  logic [N*PAYLOAD_W-1:0] in_data,
    output logic [N-1:0]           out_valid,
    output logic [N*TW-1:0]        out_dest,
    output logic [N*PAYLOAD_W-1:0] out_data,
    output logic [N*CNT_W-1:0]     drop_count
);
    import lbsw_pkg::*;

    logic [TW-1:0]     slot;
    logic [N-1:0]      arr_vld, dep_vld;
    logic [CELL_W-1:0] arr_cell [N];
    logic [CELL_W-1:0] dep_cell [N];
    logic [TW-1:0]     conn_out [N];

    lbsw_slot_ctr #(.N(N)) slot_i (.clk(clk), .rst_n(rst_n), .slot(slot));

    // stage one: middle m receives from input (m - t) mod N
    always_comb begin
        for (int m = 0; m < N; m++) begin
            int src;
            src         = wrap_sub(m, int'(slot), N);
            arr_vld[m]  = in_valid[src];
            arr_cell[m] = {in_dest[src*TW +: TW], in_data[src*PAYLOAD_W +: PAYLOAD_W]};
        end
    end

    for (genvar m = 0; m < N; m++) begin : g_mid
        lbsw_mid_port #(
            .N(N), .MID(m), .DEPTH(DEPTH), .PAYLOAD_W(PAYLOAD_W), .CNT_W(CNT_W)
        ) mid_i (
            .clk(clk), .rst_n(rst_n), .slot(slot),
            .arr_vld(arr_vld[m]), .arr_cell(arr_cell[m]),
            .conn_out(conn_out[m]),
            .dep_vld(dep_vld[m]), .dep_cell(dep_cell[m]),
            .drops(drop_count[m*CNT_W +: CNT_W])
        );
    end

    // stage two: each output takes the middle port connected to it
    always_comb begin
        out_valid = '0;
        out_dest  = '0;
        out_data  = '0;
        for (int o = 0; o < N; o++) begin
            for (int m = 0; m < N; m++) begin
                if (conn_out[m] == TW'(o)) begin
                    out_valid[o]                       = dep_vld[m];
                    out_dest[o*TW +: TW]               = dep_cell[m][CELL_W-1 -: TW];
                    out_data[o*PAYLOAD_W +: PAYLOAD_W] = dep_cell[m][PAYLOAD_W-1:0];
                end
            end
        end
    end

    for (genvar o = 0; o < N; o++) begin : g_chk
        p_out_tag_r7: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[o] |-> (out_dest[o*TW +: TW] == TW'(o)));
    end

endmodule

// File: tb/lbsw_fabric_tb_top.sv
// Bench: behavioural queue model of the fabric, compared every slot.
module lbsw_fabric_tb_top;
    localparam int N = 4;
    localparam int DEPTH = 8;
    localparam int PW = 16;
    localparam int CW = 16;
    localparam int TW = 2;

    logic clk = 0;
    logic rst_n = 0;
    logic [N-1:0]    in_valid = '0;
    logic [N*TW-1:0] in_dest = '0;
    logic [N*PW-1:0] in_data = '0;
    logic [N-1:0]    out_valid;
    logic [N*TW-1:0] out_dest;
    logic [N*PW-1:0] out_data;
    logic [N*CW-1:0] drop_count;

    always #5 clk = ~clk;

    lbsw_fabric #(.N(N), .DEPTH(DEPTH), .PAYLOAD_W(PW), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest),
        .in_data(in_data), .out_valid(out_valid), .out_dest(out_dest),
        .out_data(out_data), .drop_count(drop_count)
    );

    int errors = 0, checks = 0;
    int t_model = 0;
    int accepted = 0, delivered = 0, seq = 1;
    int mdrops [N];
    logic [PW-1:0] mq [N][N][$];
    bit done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one slot: inputs already driven; compare, then advance the model
    task automatic run_slot();
        int sz [N][N];
        #1;
        for (int o = 0; o < N; o++) begin
            int m;
            bit ev;
            m  = (o - t_model + N) % N;
            ev = mq[m][o].size() > 0;
            chk(out_valid[o] == ev, "R4 output valid", out_valid[o], ev);
            if (ev && out_valid[o]) begin
                chk(out_dest[o*TW +: TW] == TW'(o), "R7 tag", out_dest[o*TW +: TW], o);
                chk(out_data[o*PW +: PW] == mq[m][o][0], "R5 R8 payload order",
                    out_data[o*PW +: PW], mq[m][o][0]);
            end
        end
        for (int m = 0; m < N; m++)
            chk(drop_count[m*CW +: CW] == CW'(mdrops[m]), "R6 drop count",
                drop_count[m*CW +: CW], mdrops[m]);
        for (int m = 0; m < N; m++)
            for (int d = 0; d < N; d++) sz[m][d] = mq[m][d].size();
        for (int o = 0; o < N; o++) begin
            int m;
            m = (o - t_model + N) % N;
            if (out_valid[o]) delivered++;
            if (sz[m][o] > 0) void'(mq[m][o].pop_front());
        end
        for (int i = 0; i < N; i++) begin
            if (in_valid[i]) begin
                int m, d;
                m = (i + t_model) % N;
                d = int'(in_dest[i*TW +: TW]);
                if (sz[m][d] >= DEPTH) mdrops[m]++;   // R6, R10
                else begin
                    mq[m][d].push_back(in_data[i*PW +: PW]);
                    accepted++;
                end
            end
        end
        t_model = (t_model + 1) % N;   // R2
        @(negedge clk);
    endtask

    task automatic drive(input logic [N-1:0] v, input int dsel, input bit rnd);
        in_valid = v;
        for (int i = 0; i < N; i++) begin
            in_dest[i*TW +: TW] = rnd ? TW'($urandom % N) : TW'(dsel);
            in_data[i*PW +: PW] = PW'(seq);
            seq++;
        end
        run_slot();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        for (int m = 0; m < N; m++) mdrops[m] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid == '0, "R1 reset outputs", out_valid, 0);
        chk(drop_count == '0, "R1 reset drops", 0, 0);
        rst_n = 1;
        // R3 R9: a lone cell from input 1 to output 2 in slot 0 goes to
        // middle 1; it is reached when (1+t)%4 == 2, i.e. slot 1
        drive(4'b0010, 2, 0);
        chk(out_valid[2] == 1'b1, "R9 R3 lone cell next slot", out_valid[2], 1);
        drive(4'b0000, 0, 0);
        for (int k = 0; k < 6; k++) drive(4'b0000, 0, 0);
        // single cells from each input to varied outputs
        for (int k = 0; k < 12; k++) drive(4'b0001 << (k % N), k % 3, 0);
        for (int k = 0; k < 10; k++) drive(4'b0000, 0, 0);
        // uniform random traffic
        for (int k = 0; k < 400; k++) drive(4'($urandom), 0, 1);
        for (int k = 0; k < 40; k++) drive(4'b0000, 0, 0);
        // hotspot to output 0: fills the queues, overflow with pops (R6 R10)
        for (int k = 0; k < 60; k++) drive(4'b1111, 0, 0);
        chk(mdrops[0] > 0, "R6 hotspot overflow reached", mdrops[0], 1);
        // hotspot to output 3 from two inputs
        for (int k = 0; k < 40; k++) drive(4'b0101, 3, 0);
        // drain
        for (int k = 0; k < 8 * DEPTH * N; k++) drive(4'b0000, 0, 0);
        chk(out_valid == '0, "R8 drained idle", out_valid, 0);
        chk(delivered == accepted, "R8 exactly once", delivered, accepted);
        // R1: reset mid-traffic clears queues and counters
        for (int k = 0; k < 20; k++) drive(4'b1111, 1, 0);
        rst_n = 0;
        @(negedge clk);
        @(negedge clk);
        chk(out_valid == '0, "R1 reset clears queues", out_valid, 0);
        chk(drop_count == '0, "R1 reset clears drops", 0, 0);
        finish_run();
    end

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        finish_run();
    end
endmodule